// File: doc/BRIEF.md
# Speed Sensor Input Capture Stage

This block turns raw digital speed-sensor signals from a motor into timing events for a capture timer. Three sensor pins enter the block. A two-bit source selector either routes one of them as a tachogenerator signal to an edge detector, or pairs two of them as a quadrature incremental encoder. In tacho operation a one-cycle capture strobe fires on the chosen edge polarity. In encoder operation an encoder clock pulse fires on every transition of either channel, and a direction bit reports which channel leads.

The source selector has two copies. Software writes a staging copy, and the working copy picks it up on a commutation strobe. A bypass control lets a write reach the working copy at once, which is how the selector is first set up. A two-bit trigger-mode input enables the block. Its zero value switches speed sensing off entirely.

Top module: `spd_capture_stage`

## Requirements
- R1: After reset, capture_o, enc_clk_o and enc_dir_o are 0 and the working source selector is 00 (pin A).
- R2: While trig_mode is 00, no capture strobe and no encoder clock is produced, whatever the pins do.
- R3: trig_mode 01 makes only rising edges of the routed tacho pin produce a capture.
- R4: trig_mode 10 makes only falling edges of the routed tacho pin produce a capture.
- R5: trig_mode 11 makes both edges of the routed tacho pin produce a capture.
- R6: Working selector 00, 01 and 10 route pin A, B and C respectively, and edges on the other pins produce no capture.
- R7: Working selector 11 selects encoder operation (A is channel 1, B is channel 2). Each edge on A or B gives one enc_clk_o pulse, and capture_o stays 0.
- R8: At each channel-1 edge, enc_dir_o becomes 1 when channel 1 leads channel 2 (A and B differ just after the A edge) and 0 otherwise. Between channel-1 edges it holds its value.
- R9: A selector write with sel_direct=0 changes only the staging copy. The working copy takes the staged value on the clock edge where comm_evt is high.
- R10: A selector write with sel_direct=1 sets the working copy on that same clock edge.
- R11: Pins pass a two-flop synchronizer. A pin edge set up before clock edge k gives a capture_o or enc_clk_o pulse exactly one cycle wide, visible after clock edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sens_pins | input | 3 | Raw sensor pins, bit 0 = A, bit 1 = B, bit 2 = C |
| trig_mode | input | 2 | 00 off, 01 rising, 10 falling, 11 both edges |
| sel_wr | input | 1 | Write strobe for the source selector |
| sel_wdata | input | 2 | Selector value written: 00 A, 01 B, 10 C, 11 encoder |
| sel_direct | input | 1 | A write bypasses the staging copy |
| comm_evt | input | 1 | Commutation strobe that moves the staged selector into use |
| capture_o | output | 1 | One-cycle capture strobe |
| enc_clk_o | output | 1 | One-cycle encoder clock pulse |
| enc_dir_o | output | 1 | Encoder direction |

## Verification
The bench writes the selector without the bypass and then toggles the newly staged pin. A design that skipped the staging copy would capture there, and one that ignored comm_evt would never move to the new pin. It counts strobes over full pulse trains, so a detector with the wrong polarity, or one that fires on both edges when set to one, shows up as a wrong count. It also checks the exact cycle and the width of a strobe, so a missing synchronizer stage or a level where a pulse belongs is caught. Encoder sequences run in both rotation senses, so a direction formed from the wrong phase relation would report the reverse sense. The bench also confirms that encoder operation never raises the capture strobe.

// File: rtl/spd_pkg.sv
// Shared types for the speed sensor capture stage.
// Assumes the 2-bit encodings of trigger mode and source select below.
package spd_pkg;
    typedef enum logic [1:0] {
        TRIG_OFF  = 2'b00,
        TRIG_RISE = 2'b01,
        TRIG_FALL = 2'b10,
        TRIG_BOTH = 2'b11
    } trig_mode_e;

    typedef enum logic [1:0] {
        SRC_A   = 2'b00,
        SRC_B   = 2'b01,
        SRC_C   = 2'b10,
        SRC_ENC = 2'b11
    } src_sel_e;
endpackage

// File: rtl/spd_sync.sv
// Multi-stage synchronizer for asynchronous sensor pins.
// Assumes each pin is a slow level signal; output lags input by STAGES clocks.
module spd_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift the pins through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/spd_edge_bank.sv
// Per-pin edge detector on synchronized signals.
// Keeps one history flop per pin so that changing the routed pin never
// creates a false edge. Outputs are combinational single-cycle flags.
module spd_edge_bank #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] hist_q;

    // Remember last cycle's level of every pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= lvl;
        end
    end

    for (genvar g = 0; g < WIDTH; g++) begin : g_edge
        // Compare the current level with the history flop.
        always_comb begin
            rise[g] = lvl[g] & ~hist_q[g];
            fall[g] = ~lvl[g] & hist_q[g];
        end

        // R11: a rising flag can never last two cycles
        a_r11_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
            rise[g] |=> !rise[g]);
        a_r11_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
            fall[g] |=> !fall[g]);
    end
endmodule

// File: rtl/spd_sel_reg.sv
// Double-buffered source selector.
// A write lands in the staging copy. The working copy loads it on a
// commutation strobe, or loads the written data at once when direct is set.
module spd_sel_reg
    import spd_pkg::*;
#(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [SEL_W-1:0] wdata,
    input  logic             direct,
    input  logic             comm_evt,
    output logic [SEL_W-1:0] active
);
    logic [SEL_W-1:0] stage_q;
    logic [SEL_W-1:0] active_q;

    // Staging copy: takes every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (wr) begin
            stage_q <= wdata;
        end
    end

    // Working copy: direct write wins, else commutation transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
        end else if (wr && direct) begin
            active_q <= wdata;
        end else if (comm_evt) begin
            active_q <= stage_q;
        end
    end

    assign active = active_q;

    // R9: without a strobe or a direct write the working copy holds
    a_r9_hold_active: assert property (@(posedge clk) disable iff (!rst_n)
        (!comm_evt && !(wr && direct)) |=> $stable(active));
    // R10: a direct write is in use on the next cycle
    a_r10_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && direct) |=> (active == $past(wdata)));
endmodule

// File: rtl/spd_enc_if.sv
// Quadrature encoder interface.
// Produces a registered clock pulse on any channel edge and a direction
// flag refreshed at every channel-1 edge. Inputs are already synchronized.
module spd_enc_if (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ch1_lvl,
    input  logic ch2_lvl,
    input  logic ch1_edge,
    input  logic ch2_edge,
    output logic enc_clk,
    output logic enc_dir
);
    logic clk_q;
    logic dir_q;

    // One pulse per transition of either channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_q <= 1'b0;
        end else begin
            clk_q <= enable & (ch1_edge | ch2_edge);
        end
    end

    // Channel 1 leads when the channels differ right after its edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= 1'b0;
        end else if (enable && ch1_edge) begin
            dir_q <= ch1_lvl ^ ch2_lvl;
        end
    end

    assign enc_clk = clk_q;
    assign enc_dir = dir_q;

    // R8: direction moves only after a channel-1 edge in encoder use
    a_r8_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(enable && ch1_edge) |=> $stable(enc_dir));
    // R7: no pulse without an edge on either channel
    a_r7_pulse_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !(ch1_edge || ch2_edge) |=> !enc_clk);
endmodule

// File: rtl/spd_capture_stage.sv
// Speed sensor capture stage top.
// Synchronizes the pins, finds edges, routes the selected tacho pin through
// the trigger-mode filter into a registered capture strobe, or feeds the
// encoder interface when the selector picks encoder operation.
// Assumes trig_mode is a static configuration held by a register bank.
module spd_capture_stage
    import spd_pkg::*;
#(
    parameter int NUM_PINS    = 3,
    parameter int SYNC_STAGES = 2,
    parameter int SEL_W       = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] sens_pins,
    input  logic [1:0]          trig_mode,
    input  logic                sel_wr,
    input  logic [SEL_W-1:0]    sel_wdata,
    input  logic                sel_direct,
    input  logic                comm_evt,
    output logic                capture_o,
    output logic                enc_clk_o,
    output logic                enc_dir_o
);
    localparam int ENC_CH1 = 0;
    localparam int ENC_CH2 = 1;

    logic [NUM_PINS-1:0] pin_lvl;
    logic [NUM_PINS-1:0] pin_rise;
    logic [NUM_PINS-1:0] pin_fall;
    logic [SEL_W-1:0]    act_sel;
    logic                tacho_rise;
    logic                tacho_fall;
    logic                sense_on;
    logic                enc_mode;
    logic                cap_d;
    logic                cap_q;

    spd_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (sens_pins),
        .sync_out (pin_lvl)
    );

    spd_edge_bank #(.WIDTH(NUM_PINS)) edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (pin_lvl),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    spd_sel_reg #(.SEL_W(SEL_W)) sel_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (sel_wr),
        .wdata    (sel_wdata),
        .direct   (sel_direct),
        .comm_evt (comm_evt),
        .active   (act_sel)
    );

    // Route the edge flags of the selected tacho pin.
    always_comb begin
        tacho_rise = 1'b0;
        tacho_fall = 1'b0;
        case (src_sel_e'(act_sel))
            SRC_A:   begin tacho_rise = pin_rise[0]; tacho_fall = pin_fall[0]; end
            SRC_B:   begin tacho_rise = pin_rise[1]; tacho_fall = pin_fall[1]; end
            SRC_C:   begin tacho_rise = pin_rise[2]; tacho_fall = pin_fall[2]; end
            default: begin tacho_rise = 1'b0;        tacho_fall = 1'b0;        end
        endcase
    end

    // Decide whether the routed edge matches the trigger mode.
    always_comb begin
        sense_on = (trig_mode != TRIG_OFF);
        enc_mode = (act_sel == SRC_ENC);
        cap_d    = 1'b0;
        if (sense_on && !enc_mode) begin
            case (trig_mode_e'(trig_mode))
                TRIG_RISE: cap_d = tacho_rise;
                TRIG_FALL: cap_d = tacho_fall;
                TRIG_BOTH: cap_d = tacho_rise | tacho_fall;
                default:   cap_d = 1'b0;
            endcase
        end
    end

    // Register the capture strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= 1'b0;
        end else begin
            cap_q <= cap_d;
        end
    end

    spd_enc_if enc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (sense_on && enc_mode),
        .ch1_lvl  (pin_lvl[ENC_CH1]),
        .ch2_lvl  (pin_lvl[ENC_CH2]),
        .ch1_edge (pin_rise[ENC_CH1] | pin_fall[ENC_CH1]),
        .ch2_edge (pin_rise[ENC_CH2] | pin_fall[ENC_CH2]),
        .enc_clk  (enc_clk_o),
        .enc_dir  (enc_dir_o)
    );

    assign capture_o = cap_q;

    // R2: mode off silences both event outputs
    a_r2_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_mode == TRIG_OFF) |=> (!capture_o && !enc_clk_o));
    // R7: encoder operation never raises the capture strobe
    a_r7_enc_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (act_sel == SRC_ENC) |=> !capture_o);
    // R6: a capture always follows an edge on some pin
    a_r6_capture_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(pin_rise | pin_fall)) |=> !capture_o);
endmodule

// File: tb/spd_capture_stage_tb_top.sv
// Directed bench for the speed sensor capture stage.
module spd_capture_stage_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sens_pins = 3'b000;
    logic [1:0] trig_mode = 2'b00;
    logic       sel_wr = 1'b0;
    logic [1:0] sel_wdata = 2'b00;
    logic       sel_direct = 1'b0;
    logic       comm_evt = 1'b0;
    logic       capture_o;
    logic       enc_clk_o;
    logic       enc_dir_o;

    int total = 0;
    int bad = 0;
    int cap_cnt = 0;
    int enc_cnt = 0;
    bit cap_wide = 1'b0;
    bit enc_wide = 1'b0;
    bit prev_cap = 1'b0;
    bit prev_enc = 1'b0;

    spd_capture_stage dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sens_pins  (sens_pins),
        .trig_mode  (trig_mode),
        .sel_wr     (sel_wr),
        .sel_wdata  (sel_wdata),
        .sel_direct (sel_direct),
        .comm_evt   (comm_evt),
        .capture_o  (capture_o),
        .enc_clk_o  (enc_clk_o),
        .enc_dir_o  (enc_dir_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Count strobes and note any strobe wider than one cycle.
    always @(negedge clk) begin
        if (capture_o) cap_cnt++;
        if (enc_clk_o) enc_cnt++;
        if (capture_o && prev_cap) cap_wide = 1'b1;
        if (enc_clk_o && prev_enc) enc_wide = 1'b1;
        prev_cap = capture_o;
        prev_enc = enc_clk_o;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pin(input int idx, input logic val);
        @(negedge clk);
        sens_pins[idx] = val;
        idle(5);
    endtask

    task automatic write_sel(input logic [1:0] v, input logic direct);
        @(negedge clk);
        sel_wr = 1'b1; sel_wdata = v; sel_direct = direct;
        @(negedge clk);
        sel_wr = 1'b0; sel_direct = 1'b0;
    endtask

    task automatic strobe_comm();
        @(negedge clk);
        comm_evt = 1'b1;
        @(negedge clk);
        comm_evt = 1'b0;
    endtask

    // Two full pulses on one pin, returning the capture count.
    task automatic two_pulses(input int idx, output int got);
        int base;
        base = cap_cnt;
        set_pin(idx, 1'b1); set_pin(idx, 1'b0);
        set_pin(idx, 1'b1); set_pin(idx, 1'b0);
        got = cap_cnt - base;
    endtask

    task automatic t_reset();
        chk("R1 capture at reset", capture_o, 0);
        chk("R1 enc_clk at reset", enc_clk_o, 0);
        chk("R1 enc_dir at reset", enc_dir_o, 0);
        trig_mode = 2'b01;
        begin
            int got;
            two_pulses(0, got);
            chk("R1 pin A routed after reset", got, 2);
        end
    endtask

    task automatic t_off();
        int cb, eb;
        trig_mode = 2'b00;
        write_sel(2'b00, 1'b1);
        cb = cap_cnt; eb = enc_cnt;
        for (int i = 0; i < 3; i++) begin
            set_pin(i, 1'b1); set_pin(i, 1'b0);
        end
        write_sel(2'b11, 1'b1);
        set_pin(0, 1'b1); set_pin(1, 1'b1); set_pin(0, 1'b0); set_pin(1, 1'b0);
        chk("R2 no capture when off", cap_cnt - cb, 0);
        chk("R2 no encoder clock when off", enc_cnt - eb, 0);
    endtask

    task automatic t_latency();
        trig_mode = 2'b01;
        write_sel(2'b00, 1'b1);
        idle(2);
        @(negedge clk);
        sens_pins[0] = 1'b1;
        @(negedge clk);
        chk("R11 no strobe after 1 edge", capture_o, 0);
        @(negedge clk);
        chk("R11 no strobe after 2 edges", capture_o, 0);
        @(negedge clk);
        chk("R11 strobe after 3 edges", capture_o, 1);
        @(negedge clk);
        chk("R11 strobe one cycle wide", capture_o, 0);
        set_pin(0, 1'b0);
    endtask

    task automatic t_modes();
        int got;
        write_sel(2'b00, 1'b1);
        trig_mode = 2'b01; two_pulses(0, got);
        chk("R3 rising only count", got, 2);
        trig_mode = 2'b10; two_pulses(0, got);
        chk("R4 falling only count", got, 2);
        trig_mode = 2'b11; two_pulses(0, got);
        chk("R5 both edges count", got, 4);
        begin
            int base;
            trig_mode = 2'b10;
            base = cap_cnt;
            set_pin(0, 1'b1);
            chk("R4 rising edge ignored", cap_cnt - base, 0);
            set_pin(0, 1'b0);
            chk("R4 falling edge captured", cap_cnt - base, 1);
        end
    endtask

    task automatic t_route();
        int got;
        trig_mode = 2'b11;
        write_sel(2'b01, 1'b1);
        two_pulses(0, got); chk("R6 sel B ignores A", got, 0);
        two_pulses(2, got); chk("R6 sel B ignores C", got, 0);
        two_pulses(1, got); chk("R6 sel B follows B", got, 4);
        write_sel(2'b10, 1'b1);
        two_pulses(1, got); chk("R6 sel C ignores B", got, 0);
        two_pulses(2, got); chk("R6 sel C follows C", got, 4);
    endtask

    task automatic t_preload();
        int got;
        trig_mode = 2'b01;
        write_sel(2'b00, 1'b1);
        write_sel(2'b10, 1'b0);
        two_pulses(2, got); chk("R9 staged C not yet used", got, 0);
        two_pulses(0, got); chk("R9 A still in use", got, 2);
        strobe_comm();
        two_pulses(2, got); chk("R9 C used after comm_evt", got, 2);
        two_pulses(0, got); chk("R9 A dropped after comm_evt", got, 0);
    endtask

    task automatic t_direct();
        int got;
        trig_mode = 2'b01;
        write_sel(2'b01, 1'b1);
        two_pulses(1, got); chk("R10 direct write to B at once", got, 2);
    endtask

    // Quadrature step list: A leads when lead_a is set.
    task automatic quad(input bit lead_a);
        int first, second;
        first  = lead_a ? 0 : 1;
        second = lead_a ? 1 : 0;
        set_pin(first, 1'b1); set_pin(second, 1'b1);
        set_pin(first, 1'b0); set_pin(second, 1'b0);
    endtask

    task automatic t_encoder();
        int cb, eb;
        trig_mode = 2'b01;
        write_sel(2'b11, 1'b1);
        cb = cap_cnt; eb = enc_cnt;
        quad(1'b1);
        chk("R7 four clocks per cycle", enc_cnt - eb, 4);
        chk("R7 no capture in encoder use", cap_cnt - cb, 0);
        chk("R8 A leads gives dir 1", enc_dir_o, 1);
        eb = enc_cnt;
        quad(1'b0);
        chk("R7 four clocks reverse", enc_cnt - eb, 4);
        chk("R8 B leads gives dir 0", enc_dir_o, 0);
        quad(1'b1);
        chk("R8 dir back to 1", enc_dir_o, 1);
        eb = enc_cnt;
        set_pin(2, 1'b1); set_pin(2, 1'b0);
        chk("R7 pin C ignored in encoder use", enc_cnt - eb, 0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_off();
        t_latency();
        t_modes();
        t_route();
        t_preload();
        t_direct();
        t_encoder();
        chk("R11 capture never wider than one cycle", int'(cap_wide), 0);
        chk("R11 encoder clock never wider than one cycle", int'(enc_wide), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule